// File: doc/BRIEF.md
# External SRAM Bus Controller

This block turns single requests from an internal master into strobed cycles on an asynchronous static memory bus. Eight chip-select areas share the bus. Each area has its own device width, either 8 or 16 bits, and its own static wait count. The internal side uses a request/acknowledge handshake. The master raises `req` with the area index, the byte address, the byte enables, the direction and the write data, and it holds them until `ack` pulses. On a read, `rdata` is valid while `ack` is high.

The external side drives one active-low chip enable per area, a read strobe, two shared strobe pins, the address and a bidirectional 16-bit data bus. It also samples an active-low `wait_n` input. The level on `bsel_mode` selects one of two strobe conventions:

- Separate high and low write strobes.
- A single write strobe with byte-select lines.

Two registers, written through `cfg_wr`/`cfg_sel`, hold the width codes and the wait counts. The width of the boot area (index 6) comes from a strap pin.

A 16-bit request to an 8-bit area is split into two byte cycles, and the low byte goes first. Each strobe lasts one cycle, plus the static wait count, plus any extra cycles requested by `wait_n`.

Top module: `sram_bus_ctl`

## Requirements
- R1: A request seen while the block is idle starts a bus cycle on the next clock. `ack` is high for exactly one cycle, the cycle right after the last strobe cycle. On a read, `rdata` holds the data while `ack` is high.
- R2: With `wait_n` high, each strobe lasts 1+N cycles. N is the 3-bit wait field of the area, held in bits [4k+2:4k] of the wait register (`cfg_sel`=1) for area k.
- R3: After reset, every area's wait field is 7, so each strobe lasts 8 cycles.
- R4: The block looks at `wait_n` only after the static count has run out. Each cycle in which `wait_n` is sampled low adds one cycle. If `wait_n` is low for the first L strobe cycles, the strobe lasts max(N,L)+1 cycles.
- R5: Area k's width code sits in bits [2k+1:2k] of the size register (`cfg_sel`=0). Code 01 selects an 8-bit device on dq[7:0] and code 10 selects a 16-bit device. After reset, every area is 16-bit.
- R6: The reserved width codes 00 and 11 behave as 16-bit, so an access completes as a single cycle.
- R7: The width of area 6 comes from `boot_byte`: 0 selects 16-bit and 1 selects 8-bit. The size-register slot for area 6, bits [13:12], has no effect.
- R8: A 16-bit area takes one cycle. `ext_addr` is {addr[23:1],0}. Write data is driven on dq[15:0], and a read captures dq[15:0].
- R9: A request with both byte enables to an 8-bit area makes two byte cycles:
  - The first cycle uses address bit 0 = 0 and carries the low byte. The second uses bit 0 = 1 and carries the high byte.
  - Data travels on dq[7:0].
  - Between the two cycles there is one cycle with every chip enable and strobe inactive.
  - A read assembles the two bytes in that order into `rdata`.
- R10: A single-byte request to an 8-bit area makes one cycle. With `be`=01 the address bit 0 is 0 and the byte lands in `rdata[7:0]`. With `be`=10 the address bit 0 is 1, `wdata[15:8]` goes out on dq[7:0], and the byte lands in `rdata[15:8]`. The byte of `rdata` that was not accessed reads 0.
- R11: With `bsel_mode`=0, `a0_bsl` carries `ext_addr[0]`. `lo_strb_n` is low on writes that use the low lane and `hi_strb_n` is low on writes that use the high lane. Neither is active on a read.
- R12: With `bsel_mode`=1, `lo_strb_n` is the common write strobe. `a0_bsl` and `hi_strb_n` are active-low selects for the low and high lanes, and they are active on both reads and writes.
- R13: During strobe cycles, exactly the chip enable of the requested area is low; all are high at other times. The block drives `ext_dq` only during write strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the size register, 1 selects the wait register |
| cfg_wdata | input | 32 | Configuration write data |
| boot_byte | input | 1 | Boot-area width strap (1 = 8-bit) |
| bsel_mode | input | 1 | 0 selects write-strobe mode, 1 selects byte-select mode |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write |
| req_area | input | 3 | Area index |
| req_addr | input | 24 | Byte address |
| req_be | input | 2 | Byte enables (bit 0 = low byte) |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| ce_n | output | 8 | Active-low chip enables, one per area |
| rd_n | output | 1 | Active-low read strobe |
| a0_bsl | output | 1 | Address bit 0, or the low-lane select |
| lo_strb_n | output | 1 | Low write strobe, or the common write strobe |
| hi_strb_n | output | 1 | High write strobe, or the high-lane select |
| ext_addr | output | 24 | External address |
| ext_dq | inout | 16 | External data bus |
| wait_n | input | 1 | Active-low wait extension |

## Verification
The bench goes after the byte split on 8-bit areas. A design that sends the high byte first, or runs the two strobes back to back with no idle cycle, shows a wrong address bit, wrong lane data or a missing gap. It measures strobe length with `wait_n` held low for fewer cycles, and for more cycles, than the static count. A design that samples WAIT too early, or adds the two counts together, produces a strobe that is too long. It also checks reserved width codes, the boot strap against a misleading value in the boot slot, single-byte accesses to the upper lane, and the pin meaning in both strobe modes, where a swapped select or a write strobe on a read shows up directly at the pins.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } smc_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;
endpackage

// File: rtl/smc_cfg.sv
module smc_cfg
  import smc_pkg::*;
#(
  parameter int N_AREA   = 8,
  parameter int BOOT_IDX = 6,
  parameter int WAIT_W   = 3,
  parameter int CFG_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic                       cfg_sel,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic                       boot_byte,
  output logic [N_AREA-1:0]          area_byte,
  output logic [N_AREA*WAIT_W-1:0]   area_wait
);
  localparam int SZ_W    = 2 * N_AREA;
  localparam int WT_SLOT = CFG_W / N_AREA;

  logic [SZ_W-1:0]          size_q, size_d;
  logic [N_AREA*WAIT_W-1:0] wait_q, wait_d;
  logic                     size_en, wait_en;
  logic                     cfg_unused;

  assign size_en    = cfg_wr & ~cfg_sel;
  assign wait_en    = cfg_wr & cfg_sel;
  assign size_d     = cfg_wdata[SZ_W-1:0];
  assign cfg_unused = ^cfg_wdata;

  for (genvar k = 0; k < N_AREA; k++) begin : g_area
    assign wait_d[k*WAIT_W +: WAIT_W] = cfg_wdata[k*WT_SLOT +: WAIT_W];
    if (k == BOOT_IDX) begin : g_boot
      assign area_byte[k] = boot_byte;
    end else begin : g_prog
      // reserved codes fall through to 16-bit
      assign area_byte[k] = (size_q[2*k +: 2] == SZ_BYTE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= {N_AREA{SZ_HALF}};
      wait_q <= {(N_AREA*WAIT_W){1'b1}};
    end else begin
      if (size_en) size_q <= size_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  assign area_wait = wait_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(area_wait)); // R2
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int N_AREA = 8,
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int WAIT_W = 3,
  parameter int AIW    = $clog2(N_AREA)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     req_we,
  input  logic [AIW-1:0]           req_area,
  input  logic [AW-1:0]            req_addr,
  input  logic [1:0]               req_be,
  input  logic [DW-1:0]            req_wdata,
  output logic                     ack,
  output logic [DW-1:0]            rdata,
  input  logic [N_AREA-1:0]        area_byte,
  input  logic [N_AREA*WAIT_W-1:0] area_wait,
  input  logic                     wait_n,
  input  logic [DW-1:0]            bus_din,
  output logic                     act,
  output logic                     drive,
  output logic                     is_wr,
  output logic                     lane_lo,
  output logic                     lane_hi,
  output logic [AIW-1:0]           cur_area,
  output logic [AW-1:0]            bus_addr,
  output logic [DW-1:0]            bus_dout
);
  localparam int BW = DW / 2;

  smc_state_e        st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              hi_q, hi_d, two_q, two_d;
  logic              ld_req, ld_rd;
  logic [AIW-1:0]    area_q;
  logic [AW-1:0]     addr_q;
  logic [1:0]        be_q;
  logic              we_q, byte_q;
  logic [DW-1:0]     wd_q, rd_q, rd_d;
  logic [WAIT_W-1:0] wait_req, wait_cur;
  logic              addr_unused;

  assign wait_req    = area_wait[req_area*WAIT_W +: WAIT_W];
  assign wait_cur    = area_wait[area_q*WAIT_W +: WAIT_W];
  assign addr_unused = addr_q[0];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    two_d  = two_q;
    ld_req = 1'b0;
    ld_rd  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        ld_req = 1'b1;
        st_d   = ST_STRB;
        cnt_d  = wait_req;
        hi_d   = area_byte[req_area] & (req_be == 2'b10);
        two_d  = area_byte[req_area] & (req_be == 2'b11);
      end
      ST_STRB: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (wait_n) begin
          ld_rd = ~we_q;
          if (two_q) begin
            two_d = 1'b0;
            hi_d  = 1'b1;
            st_d  = ST_GAP;
          end else begin
            st_d  = ST_DONE;
          end
        end
      end
      ST_GAP: begin
        cnt_d = wait_cur;
        st_d  = ST_STRB;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (!byte_q)   rd_d = bus_din;
    else if (hi_q) rd_d = {bus_din[BW-1:0], rd_q[BW-1:0]};
    else           rd_d = {rd_q[DW-1:BW], bus_din[BW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      hi_q  <= 1'b0;
      two_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      two_q <= two_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_q <= '0;
      addr_q <= '0;
      be_q   <= '0;
      we_q   <= 1'b0;
      byte_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else if (ld_req) begin
      area_q <= req_area;
      addr_q <= req_addr;
      be_q   <= req_be;
      we_q   <= req_we;
      byte_q <= area_byte[req_area];
      wd_q   <= req_wdata;
      rd_q   <= '0;
    end else if (ld_rd) begin
      rd_q   <= rd_d;
    end
  end

  assign act      = (st_q == ST_STRB);
  assign ack      = (st_q == ST_DONE);
  assign rdata    = rd_q;
  assign is_wr    = we_q;
  assign drive    = act & we_q;
  assign lane_lo  = byte_q | be_q[0];
  assign lane_hi  = ~byte_q & be_q[1];
  assign cur_area = area_q;
  assign bus_addr = {addr_q[AW-1:1], byte_q & hi_q};
  assign bus_dout = byte_q ? {{BW{1'b0}}, (hi_q ? wd_q[DW-1:BW] : wd_q[BW-1:0])} : wd_q;

  AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt_q != '0) |=> (act && cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_WAIT_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt_q == '0 && !wait_n) |=> act); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R1
  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (byte_q && hi_q && bus_addr[0])); // R9
endmodule

// File: rtl/smc_pins.sv
module smc_pins #(
  parameter int N_AREA = 8,
  parameter int AIW    = $clog2(N_AREA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsel_mode,
  input  logic              act,
  input  logic              is_wr,
  input  logic              lane_lo,
  input  logic              lane_hi,
  input  logic [AIW-1:0]    cur_area,
  input  logic              addr_b0,
  output logic [N_AREA-1:0] ce_n,
  output logic              rd_n,
  output logic              a0_bsl,
  output logic              lo_strb_n,
  output logic              hi_strb_n
);
  for (genvar k = 0; k < N_AREA; k++) begin : g_ce
    assign ce_n[k] = ~(act && (cur_area == AIW'(k)));
  end

  always_comb begin
    rd_n = ~(act & ~is_wr);
    if (bsel_mode) begin
      a0_bsl    = ~(act & lane_lo);
      lo_strb_n = ~(act & is_wr);
      hi_strb_n = ~(act & lane_hi);
    end else begin
      a0_bsl    = addr_b0;
      lo_strb_n = ~(act & is_wr & lane_lo);
      hi_strb_n = ~(act & is_wr & lane_hi);
    end
  end

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n)); // R13
  AST_NO_WR_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> lo_strb_n); // R11
endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import smc_pkg::*;
#(
  parameter int N_AREA   = 8,
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int WAIT_W   = 3,
  parameter int CFG_W    = 32,
  parameter int BOOT_IDX = 6,
  parameter int AIW      = $clog2(N_AREA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              boot_byte,
  input  logic              bsel_mode,
  input  logic              req,
  input  logic              req_we,
  input  logic [AIW-1:0]    req_area,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic [N_AREA-1:0] ce_n,
  output logic              rd_n,
  output logic              a0_bsl,
  output logic              lo_strb_n,
  output logic              hi_strb_n,
  output logic [AW-1:0]     ext_addr,
  inout  wire  [DW-1:0]     ext_dq,
  input  logic              wait_n
);
  logic [1:0]               rst_pipe;
  logic                     srst_n;
  logic [N_AREA-1:0]        area_byte;
  logic [N_AREA*WAIT_W-1:0] area_wait;
  logic                     act, drive, is_wr, lane_lo, lane_hi;
  logic [AIW-1:0]           cur_area;
  logic [DW-1:0]            bus_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  smc_cfg #(.N_AREA(N_AREA), .BOOT_IDX(BOOT_IDX), .WAIT_W(WAIT_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .boot_byte(boot_byte), .area_byte(area_byte), .area_wait(area_wait));

  smc_seq #(.N_AREA(N_AREA), .AW(AW), .DW(DW), .WAIT_W(WAIT_W), .AIW(AIW)) u_seq (
    .clk(clk), .rst_n(srst_n), .req(req), .req_we(req_we), .req_area(req_area),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .area_byte(area_byte), .area_wait(area_wait), .wait_n(wait_n), .bus_din(ext_dq),
    .act(act), .drive(drive), .is_wr(is_wr), .lane_lo(lane_lo), .lane_hi(lane_hi),
    .cur_area(cur_area), .bus_addr(ext_addr), .bus_dout(bus_dout));

  smc_pins #(.N_AREA(N_AREA), .AIW(AIW)) u_pins (
    .clk(clk), .rst_n(srst_n), .bsel_mode(bsel_mode), .act(act), .is_wr(is_wr),
    .lane_lo(lane_lo), .lane_hi(lane_hi), .cur_area(cur_area), .addr_b0(ext_addr[0]),
    .ce_n(ce_n), .rd_n(rd_n), .a0_bsl(a0_bsl), .lo_strb_n(lo_strb_n), .hi_strb_n(hi_strb_n));

  assign ext_dq = drive ? bus_dout : {DW{1'bz}};

  AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    drive |-> (rd_n && ce_n != '1)); // R13
endmodule

// File: tb/sim_sram_bus_ctl.sv
module sim_sram_bus_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk, rst_n, cfg_wr, cfg_sel, boot_byte, bsel_mode;
  logic [31:0] cfg_wdata;
  logic        req, req_we, wait_n;
  logic [2:0]  req_area;
  logic [23:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        ack, rd_n, a0_bsl, lo_strb_n, hi_strb_n;
  logic [15:0] rdata;
  logic [7:0]  ce_n;
  logic [23:0] ext_addr;
  wire  [15:0] ext_dq;

  int n_chk = 0;
  int n_fail = 0;

  // memory model: drives the bus while the read strobe is low
  assign ext_dq = (!rd_n) ? {~ext_addr[7:0], ext_addr[7:0] ^ 8'h5A} : 16'hzzzz;

  sram_bus_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .boot_byte(boot_byte), .bsel_mode(bsel_mode), .req(req), .req_we(req_we),
    .req_area(req_area), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .ce_n(ce_n), .rd_n(rd_n), .a0_bsl(a0_bsl),
    .lo_strb_n(lo_strb_n), .hi_strb_n(hi_strb_n), .ext_addr(ext_addr), .ext_dq(ext_dq),
    .wait_n(wait_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // results of the last transfer
  int          np, plen [2];
  logic [23:0] paddr [2];
  logic [7:0]  pce [2];
  logic        pa0 [2], plo [2], phi [2], prd [2];
  logic [15:0] pdq [2];
  logic        gap_bad, ack_ok, ack_drop;
  logic [15:0] rdat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic xfer(input int area, input logic [23:0] addr, input logic [1:0] be,
                      input logic we, input logic [15:0] wd, input int lowcyc);
    int  cur;
    bit  prev, done;
    @(negedge clk);
    req = 1'b1; req_we = we; req_area = area[2:0]; req_addr = addr; req_be = be;
    req_wdata = wd; wait_n = (lowcyc == 0);
    np = 0; cur = 0; prev = 0; done = 0; gap_bad = 0; ack_ok = 0; rdat = '0;
    for (int it = 0; it < 300 && !done; it++) begin
      @(negedge clk);
      if (ce_n != 8'hFF) begin
        if (!prev) begin
          if (np < 2) begin
            paddr[np] = ext_addr; pce[np] = ce_n; pa0[np] = a0_bsl; plo[np] = lo_strb_n;
            phi[np] = hi_strb_n; prd[np] = rd_n; pdq[np] = ext_dq; plen[np] = 0;
          end
          np++; cur = 0;
        end
        cur++;
        if (np <= 2) plen[np-1] = cur;
        wait_n = (cur > lowcyc);
        prev = 1;
      end else begin
        if (ack) begin
          ack_ok = prev; rdat = rdata; req = 1'b0; done = 1;
        end else if (np > 0 && (rd_n !== 1'b1 || lo_strb_n !== 1'b1 || hi_strb_n !== 1'b1 ||
                                (bsel_mode && a0_bsl !== 1'b1))) begin
          gap_bad = 1;
        end
        prev = 0;
      end
    end
    wait_n = 1'b1;
    @(negedge clk);
    ack_drop = (ack == 1'b0);
    chk("R1 ack after last strobe", {31'd0, ack_ok}, 32'd1);
    chk("R1 ack single cycle", {31'd0, ack_drop}, 32'd1);
    chk("R13 chip enable of area", {24'd0, pce[0]}, {24'd0, ~(8'd1 << area)});
  endtask

  task automatic t_reset();
    chk("R13 ce idle after reset", {24'd0, ce_n}, 32'h0000_00FF);
    chk("R13 strobes idle after reset", {29'd0, rd_n, lo_strb_n, hi_strb_n}, 32'd7);
    chk("R13 dq released after reset", {16'd0, ext_dq}, {16'd0, 16'hzzzz});
    chk("R1 no ack after reset", {31'd0, ack}, 32'd0);
  endtask

  task automatic t_defaults();
    xfer(0, 24'h000100, 2'b11, 1'b0, 16'h0000, 0);
    chk("R3 reset wait gives 8 cycles", plen[0], 32'd8);
    chk("R8 16-bit read data", {16'd0, rdat}, 32'h0000_FF5A);
    chk("R11 read has no write strobes", {30'd0, plo[0], phi[0]}, 32'd3);
    chk("R8 read strobe low", {31'd0, prd[0]}, 32'd0);
    xfer(1, 24'h000102, 2'b11, 1'b0, 16'h0000, 0);
    chk("R5 reset width is 16-bit", np, 32'd1);
    chk("R5 reset width 16-bit data", {16'd0, rdat}, 32'h0000_FD58);
  endtask

  task automatic t_static();
    xfer(0, 24'h000200, 2'b11, 1'b1, 16'hBEEF, 0);
    chk("R2 wait 0 gives 1 cycle", plen[0], 32'd1);
    chk("R8 write data on bus", {16'd0, pdq[0]}, 32'h0000_BEEF);
    chk("R8 address bit0 zero", {31'd0, paddr[0][0]}, 32'd0);
    chk("R11 both write strobes", {30'd0, plo[0], phi[0]}, 32'd0);
    chk("R11 a0 follows address", {31'd0, pa0[0]}, 32'd0);
    xfer(5, 24'h000300, 2'b01, 1'b1, 16'h1234, 0);
    chk("R2 wait 5 gives 6 cycles", plen[0], 32'd6);
    chk("R11 low lane only", {30'd0, plo[0], phi[0]}, 32'd1);
  endtask

  task automatic t_reserved();
    xfer(2, 24'h000400, 2'b11, 1'b0, 16'h0000, 0);
    chk("R6 code 00 single cycle", np, 32'd1);
    chk("R6 code 00 16-bit data", {16'd0, rdat}, 32'h0000_FF5A);
    xfer(3, 24'h000402, 2'b11, 1'b0, 16'h0000, 0);
    chk("R6 code 11 single cycle", np, 32'd1);
    chk("R6 code 11 16-bit data", {16'd0, rdat}, 32'h0000_FD58);
  endtask

  task automatic t_split();
    xfer(1, 24'h000122, 2'b11, 1'b1, 16'hA1B2, 0);
    chk("R9 two byte cycles", np, 32'd2);
    chk("R9 lengths", {plen[0][15:0], plen[1][15:0]}, {16'd2, 16'd2});
    chk("R9 low byte first address", {30'd0, paddr[0][0], paddr[1][0]}, 32'd1);
    chk("R9 byte order on dq", {16'd0, pdq[0][7:0], pdq[1][7:0]}, 32'h0000_B2A1);
    chk("R9 idle gap between cycles", {31'd0, gap_bad}, 32'd0);
    chk("R5 8-bit write uses low strobe", {28'd0, plo[0], phi[0], plo[1], phi[1]}, 32'h5);
    xfer(1, 24'h000122, 2'b11, 1'b0, 16'h0000, 0);
    chk("R9 assembled read", {16'd0, rdat}, 32'h0000_7978);
  endtask

  task automatic t_single_byte();
    xfer(1, 24'h000144, 2'b10, 1'b0, 16'h0000, 0);
    chk("R10 high byte single cycle", np, 32'd1);
    chk("R10 high byte address", {8'd0, paddr[0]}, 32'h0000_0145);
    chk("R10 high byte read", {16'd0, rdat}, 32'h0000_1F00);
    xfer(1, 24'h000144, 2'b01, 1'b1, 16'h55CC, 0);
    chk("R10 low byte write address", {8'd0, paddr[0]}, 32'h0000_0144);
    chk("R10 low byte write data", {24'd0, pdq[0][7:0]}, 32'h0000_00CC);
    xfer(1, 24'h000144, 2'b10, 1'b1, 16'h55CC, 0);
    chk("R10 high byte write data", {24'd0, pdq[0][7:0]}, 32'h0000_0055);
    chk("R10 high byte write bit0", {31'd0, paddr[0][0]}, 32'd1);
  endtask

  task automatic t_boot();
    boot_byte = 1'b0;
    xfer(6, 24'h000500, 2'b11, 1'b0, 16'h0000, 0);
    chk("R7 strap 0 is 16-bit", np, 32'd1);
    chk("R2 area 6 wait 6", plen[0], 32'd7);
    boot_byte = 1'b1;
    xfer(6, 24'h000500, 2'b11, 1'b0, 16'h0000, 0);
    chk("R7 strap 1 is 8-bit", np, 32'd2);
    boot_byte = 1'b0;
  endtask

  task automatic t_dynamic();
    xfer(2, 24'h000600, 2'b11, 1'b0, 16'h0000, 5);
    chk("R4 wait low past static", plen[0], 32'd6);
    xfer(5, 24'h000600, 2'b11, 1'b0, 16'h0000, 3);
    chk("R4 wait low within static", plen[0], 32'd6);
    xfer(0, 24'h000600, 2'b11, 1'b1, 16'h0F0F, 4);
    chk("R4 wait on zero static", plen[0], 32'd5);
  endtask

  task automatic t_bytesel();
    bsel_mode = 1'b1;
    xfer(4, 24'h000700, 2'b10, 1'b1, 16'h9900, 0);
    chk("R12 write strobe and high select", {30'd0, plo[0], phi[0]}, 32'd0);
    chk("R12 low select off", {31'd0, pa0[0]}, 32'd1);
    chk("R2 area 4 wait 4", plen[0], 32'd5);
    xfer(4, 24'h000700, 2'b01, 1'b0, 16'h0000, 0);
    chk("R12 read selects low lane", {29'd0, pa0[0], plo[0], phi[0]}, 32'd3);
    chk("R12 read data", {16'd0, rdat}, 32'h0000_FF5A);
    bsel_mode = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; boot_byte = 1'b0;
    bsel_mode = 1'b0; req = 1'b0; req_we = 1'b0; req_area = '0; req_addr = '0;
    req_be = '0; req_wdata = '0; wait_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_defaults();
    cfg_write(1'b1, 32'h7654_3210);
    cfg_write(1'b0, 32'h0000_9AC6);
    t_static();
    t_reserved();
    t_split();
    t_single_byte();
    t_boot();
    t_dynamic();
    t_bytesel();
    summary();
    $finish;
  end
endmodule